// File: doc/BRIEF.md
# Per-Context Extension Control Register File

This block sits inside a stateful extension unit and keeps a small set of control registers for each of the unit's private state contexts. A request names a context, a 12-bit register address, an access kind and an operand value. One cycle after the request is accepted, the block returns the value the register held before the access and a status code. The access is carried out on that register of the named context and on no other register.

Four access kinds are supported: a plain read, a write that replaces the value, a set that ORs the operand in, and a clear that removes the operand's bits. An address the unit does not implement returns an error status and changes nothing. A context index beyond the number of contexts also returns an error status and changes nothing. Privilege and read-only checks are made upstream, before a request reaches this block.

The implemented registers sit at `CSR_BASE + i*CSR_STRIDE` for i = 0 .. NUM_CSR-1, inside the 0x800-0x8FF window. With the default parameters these addresses are 0x840, 0x844, 0x848 and 0x84C, and there are four contexts.

Top module: `cxcsr_file`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rsp_valid` and `req_ready` are 0. Every register of every context reads as zero after reset.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the one cycle after each accepted request and is 0 otherwise. `req_ready` is 1 whenever reset is low.
- R3: For an access that succeeds, `rsp_status` is 0 (OK) and `rsp_rdata` is the value the register held before the access.
- R4: Access kind 2'b01 (write) sets the register to `req_wdata`.
- R5: Access kind 2'b10 (set) sets the register to its old value OR `req_wdata`.
- R6: Access kind 2'b11 (clear) sets the register to its old value AND NOT `req_wdata`.
- R7: Access kind 2'b00 (read) leaves the register unchanged, whatever the value of `req_wdata`.
- R8: For an address that is not `CSR_BASE + i*CSR_STRIDE` with i < NUM_CSR, `rsp_status` is 1 (ERROR_FUNC), `rsp_rdata` is 0 and no register changes.
- R9: For a context index of NUM_CTX or more, `rsp_status` is 1, `rsp_rdata` is 0 and no register changes, even when the address is implemented.
- R10: An access to context c changes no register of any other context, and it reads only context c.
- R11: Register i of a context is reached at address `CSR_BASE + i*CSR_STRIDE`, and each implemented address reaches its own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The block accepts a request this cycle |
| req_ctx | input | CTX_W (3) | Context index, one bit wider than needed, so that out-of-range indices can be expressed |
| req_addr | input | 12 | Register address |
| req_type | input | 2 | Access kind: 00 read, 01 write, 10 set, 11 clear |
| req_wdata | input | XLEN (32) | Operand |
| rsp_valid | output | 1 | The response is present (one cycle) |
| rsp_status | output | 1 | 0 OK, 1 ERROR_FUNC |
| rsp_rdata | output | XLEN (32) | Old register value; 0 on error |

## Verification
The assertions check the handshake timing on every cycle: the quiet state during and after reset, a response exactly one cycle after each accepted request and no other response, and error responses that carry zero data. They also check that an out-of-range context or an unimplemented address always produces the error status. The register arithmetic of the four access kinds, the return of the old value, the isolation between contexts and the proof that a rejected request leaves every register intact depend on what is stored. Only the bench shows these, by sweeping every context, register and access kind and reading the registers back.

// File: rtl/cxcsr_pkg.sv
package cxcsr_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_SET   = 2'b10,
    ACC_CLEAR = 2'b11
  } acc_e;

  localparam logic STAT_OK       = 1'b0;
  localparam logic STAT_ERR_FUNC = 1'b1;
endpackage

// File: rtl/cxcsr_decode.sv
// Maps a 12-bit address onto a register slot using the base/stride layout.
module cxcsr_decode #(
  parameter int unsigned NUM_CSR    = 4,
  parameter int unsigned CSR_BASE   = 'h840,
  parameter int unsigned CSR_STRIDE = 4,
  parameter int unsigned IDX_W      = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1
) (
  input  logic [11:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic [NUM_CSR-1:0] match;

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_match
    localparam logic [11:0] SLOT_ADDR = 12'(CSR_BASE + i * CSR_STRIDE);
    assign match[i] = (addr == SLOT_ADDR);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = NUM_CSR - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/cxcsr_update.sv
// Computes the next register value for one access kind.
module cxcsr_update
  import cxcsr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  acc_e            acc,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] new_val,
  output logic            modifies
);
  always_comb begin
    new_val  = old_val;
    modifies = 1'b1;
    unique case (acc)
      ACC_READ:  modifies = 1'b0;
      ACC_WRITE: new_val = operand;
      ACC_SET:   new_val = old_val | operand;
      ACC_CLEAR: new_val = old_val & ~operand;
      default:   modifies = 1'b0;
    endcase
  end
endmodule

// File: rtl/cxcsr_store.sv
// Register storage: NUM_CTX banks of NUM_CSR words, with one write port and one read port.
module cxcsr_store #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned NUM_CSR = 4,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CIDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int unsigned IDX_W   = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CIDX_W-1:0] ctx,
  input  logic [IDX_W-1:0]  idx,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata
);
  logic [NUM_CSR-1:0][XLEN-1:0] bank [NUM_CTX];

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[c] <= '0;
      end else if (we && (ctx == CIDX_W'(c))) begin
        bank[c][idx] <= wdata;
      end
    end
  end

  assign rdata = bank[ctx][idx];
endmodule

// File: rtl/cxcsr_file.sv
module cxcsr_file
  import cxcsr_pkg::*;
#(
  parameter int unsigned NUM_CTX    = 4,
  parameter int unsigned NUM_CSR    = 4,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CSR_BASE   = 'h840,
  parameter int unsigned CSR_STRIDE = 4,
  parameter int unsigned CTX_W      = ((NUM_CTX > 1) ? $clog2(NUM_CTX) : 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [11:0]      req_addr,
  input  logic [1:0]       req_type,
  input  logic [XLEN-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic             rsp_status,
  output logic [XLEN-1:0]  rsp_rdata
);
  localparam int unsigned CIDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int unsigned IDX_W  = (NUM_CSR > 1) ? $clog2(NUM_CSR) : 1;

  logic              ready_q;
  logic              fire;
  logic              ctx_ok;
  logic              addr_hit;
  logic [IDX_W-1:0]  slot;
  logic [XLEN-1:0]   old_val;
  logic [XLEN-1:0]   new_val;
  logic              modifies;
  logic              access_ok;
  acc_e              acc;

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;
  assign ctx_ok    = (req_ctx < CTX_W'(NUM_CTX));
  assign access_ok = ctx_ok && addr_hit;
  assign acc       = acc_e'(req_type);

  cxcsr_decode #(
    .NUM_CSR(NUM_CSR), .CSR_BASE(CSR_BASE), .CSR_STRIDE(CSR_STRIDE), .IDX_W(IDX_W)
  ) i_decode (
    .addr(req_addr), .hit(addr_hit), .idx(slot)
  );

  cxcsr_store #(
    .NUM_CTX(NUM_CTX), .NUM_CSR(NUM_CSR), .XLEN(XLEN), .CIDX_W(CIDX_W), .IDX_W(IDX_W)
  ) i_store (
    .clk(clk), .rst(rst),
    .we(fire && access_ok && modifies),
    .ctx(req_ctx[CIDX_W-1:0]), .idx(slot),
    .wdata(new_val), .rdata(old_val)
  );

  cxcsr_update #(.XLEN(XLEN)) i_update (
    .acc(acc), .old_val(old_val), .operand(req_wdata),
    .new_val(new_val), .modifies(modifies)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= STAT_OK;
      rsp_rdata  <= '0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= fire;
      if (fire) begin
        rsp_status <= access_ok ? STAT_OK : STAT_ERR_FUNC;
        rsp_rdata  <= access_ok ? old_val : '0;
      end
    end
  end
endmodule

// File: rtl/cxcsr_file_chk.sv
module cxcsr_file_chk #(
  parameter int unsigned NUM_CTX    = 4,
  parameter int unsigned NUM_CSR    = 4,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned CSR_BASE   = 'h840,
  parameter int unsigned CSR_STRIDE = 4,
  parameter int unsigned CTX_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CTX_W-1:0] req_ctx,
  input logic [11:0]      req_addr,
  input logic             rsp_valid,
  input logic             rsp_status,
  input logic [XLEN-1:0]  rsp_rdata
);
  function automatic logic addr_known(input logic [11:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (a == 12'(CSR_BASE + i * CSR_STRIDE)) r = 1'b1;
    end
    return r;
  endfunction

  // R1: quiet outputs on the cycle after a reset cycle
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !req_ready));

  // R2: a response follows every accepted request
  p_rsp_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R2: no response without an accepted request
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R8: unimplemented address gives the error status
  p_unknown_addr_err_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !addr_known(req_addr)) |=> rsp_status);

  // R9: out-of-range context gives the error status
  p_bad_ctx_err_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_ctx >= CTX_W'(NUM_CTX))) |=> rsp_status);

  // R8: error responses carry zero data
  p_err_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status) |-> (rsp_rdata == '0));
endmodule

bind cxcsr_file cxcsr_file_chk #(
  .NUM_CTX(NUM_CTX), .NUM_CSR(NUM_CSR), .XLEN(XLEN),
  .CSR_BASE(CSR_BASE), .CSR_STRIDE(CSR_STRIDE), .CTX_W(CTX_W)
) i_cxcsr_file_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_ctx(req_ctx), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .rsp_rdata(rsp_rdata)
);

// File: tb/test_cxcsr_file.sv
`timescale 1ns/1ps
module test_cxcsr_file;
  localparam int NCTX   = 4;
  localparam int NCSR   = 4;
  localparam int XL     = 32;
  localparam int BASE   = 'h840;
  localparam int STRIDE = 4;
  localparam int CW     = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_ctx = '0;
  logic [11:0]   req_addr = '0;
  logic [1:0]    req_type = '0;
  logic [XL-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_status;
  logic [XL-1:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [XL-1:0] model [NCTX][NCSR];

  always #2 clk = ~clk;

  cxcsr_file i_cxcsr_file (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_addr(req_addr), .req_type(req_type),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] slot_addr(input int i);
    return 12'(BASE + i * STRIDE);
  endfunction

  // One request at a negedge; the response is sampled at the following negedge.
  task automatic access(input int ctx, input logic [11:0] addr, input int slot,
                        input logic [1:0] kind, input logic [XL-1:0] wd,
                        input string tag);
    logic [XL-1:0] exp_data;
    logic          exp_err;
    exp_err  = (ctx >= NCTX) || (slot < 0);
    exp_data = exp_err ? '0 : model[ctx][slot];
    req_valid = 1'b1;
    req_ctx   = CW'(ctx);
    req_addr  = addr;
    req_type  = kind;
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({"R2 rsp_valid ", tag}, {31'b0, rsp_valid}, 1);
    check({tag, " status"}, {31'b0, rsp_status}, {31'b0, exp_err});
    check({"R3 old value ", tag}, rsp_rdata, exp_data);
    if (!exp_err) begin
      case (kind)
        2'b01: model[ctx][slot] = wd;
        2'b10: model[ctx][slot] = model[ctx][slot] | wd;
        2'b11: model[ctx][slot] = model[ctx][slot] & ~wd;
        default: ;
      endcase
    end
  endtask

  task automatic readback_all(input string tag);
    for (int c = 0; c < NCTX; c++)
      for (int i = 0; i < NCSR; i++)
        access(c, slot_addr(i), i, 2'b00, 32'hFFFF_FFFF, tag);
  endtask

  initial begin
    for (int c = 0; c < NCTX; c++)
      for (int i = 0; i < NCSR; i++)
        model[c][i] = '0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 0);
    check("R1 req_ready in reset", {31'b0, req_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 req_ready after reset", {31'b0, req_ready}, 1);
    check("R1 rsp_valid idle", {31'b0, rsp_valid}, 0);
    readback_all("R1 zero after reset");
    @(negedge clk);
    check("R2 no response when idle", {31'b0, rsp_valid}, 0);

    // Sweep: every context, slot and access kind, two rounds of operands
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < NCTX; c++)
        for (int i = 0; i < NCSR; i++)
          for (int k = 0; k < 4; k++) begin
            logic [1:0] kind;
            logic [XL-1:0] wd;
            string tag;
            kind = 2'((k + 1) % 4);
            wd = (32'h1357_9BDF * 32'(c * 16 + i * 4 + k + 1 + r * 64)) ^ 32'(r * 32'h00FF_0F0F);
            case (kind)
              2'b00: tag = "R7 read";
              2'b01: tag = "R4 write";
              2'b10: tag = "R5 set";
              default: tag = "R6 clear";
            endcase
            access(c, slot_addr(i), i, kind, wd, {tag, " R11"});
          end
    readback_all("R7 R10 R11 readback after sweep");

    // Unimplemented addresses, every kind
    for (int k = 0; k < 4; k++) begin
      access(0, slot_addr(0) + 12'd1, -1, 2'(k), 32'hFFFF_FFFF, "R8 miss +1");
      access(1, slot_addr(NCSR), -1, 2'(k), 32'hFFFF_FFFF, "R8 miss past end");
      access(2, slot_addr(0) - 12'(STRIDE), -1, 2'(k), 32'hFFFF_FFFF, "R8 miss below");
      access(3, 12'h940, -1, 2'(k), 32'hFFFF_FFFF, "R8 miss other window");
    end
    readback_all("R8 unchanged after misses");

    // Out-of-range contexts with implemented addresses
    for (int c = NCTX; c < (1 << CW); c++)
      for (int k = 0; k < 4; k++)
        access(c, slot_addr(c % NCSR), -1, 2'(k), 32'hA5A5_A5A5, "R9 bad context");
    readback_all("R9 unchanged after bad contexts");

    // Isolation: write one context, the others keep their values
    access(2, slot_addr(1), 1, 2'b01, 32'hDEAD_BEEF, "R10 R4 write ctx2");
    access(1, slot_addr(1), 1, 2'b00, 32'h0, "R10 neighbour ctx1");
    access(3, slot_addr(1), 1, 2'b00, 32'h0, "R10 neighbour ctx3");
    access(2, slot_addr(1), 1, 2'b11, 32'hFFFF_FFFF, "R10 R6 clear all ctx2");
    access(2, slot_addr(1), 1, 2'b10, 32'h0000_0000, "R5 set zero ctx2");
    access(2, slot_addr(1), 1, 2'b00, 32'h0, "R6 cleared to zero");
    readback_all("R10 final readback");

    @(negedge clk);
    check("R2 no response at end", {31'b0, rsp_valid}, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule